// File: doc/BRIEF.md
# Charge Current Gating Modulator

This block drives the enable line of one channel's charge switch. A charge sequencer supplies the current phase. The block turns that phase, two three-level timer-mode selections and a pair of sense-comparator flags into a single registered enable. In fast charge it works as a bang-bang regulator: the flags for "current below the low threshold" and "current above the high threshold" switch the enable on and off, and between the two thresholds the enable keeps its last value. A minimum hold time between switching events caps the switching rate. In top-off, a repeating window gates the regulated enable: on for a few time-base ticks, then off for many more. In pre-charge pending and in maintenance, a short pulse is let through once per trickle period. That period is twice as long when top-off is selected, so the trickle rate is halved.

When an external regulator supplies the current, the sense input is grounded and the `ext_reg` strap is set. The enable then follows the phase window alone. A time-base tick, typically one per second for the windows, advances all window timing. The hysteresis hold is counted in clock cycles.

The windowing is a state machine with six states. `S_IDLE` is the forced-off state. `S_FAST` is a continuous window. `S_TOP_ON` and `S_TOP_OFF` make up the top-off window. `S_TRK_ON` and `S_TRK_WAIT` make up the trickle pulse. Whenever the phase asks for a different kind of window, the machine jumps to that window's entry state (`S_FAST`, `S_TOP_ON`, `S_TRK_ON` or `S_IDLE`) and its tick counter is cleared. Within a window it moves `S_TOP_ON`→`S_TOP_OFF`→`S_TOP_ON` and `S_TRK_ON`→`S_TRK_WAIT`→`S_TRK_ON` when the tick counter reaches the length of the current state.

Top module: `chg_gate_mod`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `gate_en` is 0.
- R2: Phase codes are 3'd0 off (covering discharge, battery absent and complete without trickle), 3'd1 pending, 3'd2 fast, 3'd3 top-off and 3'd4 maintenance. Codes 5 to 7 act as off. Two clock edges after the phase becomes off, `gate_en` is 0 and stays 0.
- R3: With `ext_reg`=0, `sense_hi`=1 turns the regulator state off and `sense_lo`=1 turns it on. When both flags are 1, `sense_hi` wins. When both are 0, the state holds. `gate_en` follows a change of the regulator state two edges after the flag is sampled.
- R4: Two changes of the regulator state are at least `HOLD_CYC` clock cycles apart. A change requested earlier than that takes effect at the first edge where it is allowed.
- R5: With `ext_reg`=1 the sense flags are ignored, and `gate_en` equals the window of the current phase.
- R6: Fast phase: the window is continuously open. `gate_en` is 1 from the second edge after entry while the regulator state is on (or `ext_reg`=1).
- R7: Mode codes are 2'b00 low, 2'b10 high and anything else float. Top-off is enabled only when `tm_b` is high. When it is enabled, after edge k of the top-off phase (k≥1, tick every cycle), the window is open when (k−1) mod (`TOP_ON_TICKS`+`TOP_OFF_TICKS`) < `TOP_ON_TICKS`. When it is disabled, the window stays closed for any `tm_a`.
- R8: In pending and maintenance, after edge k, the window is open when (k−1) mod P < `PULSE_TICKS`. P is 64·`PULSE_TICKS` when `tm_b` is high and 32·`PULSE_TICKS` otherwise.
- R9: When `tm_a` and `tm_b` are both low, the trickle window in pending and maintenance stays closed.
- R10: The top-off and trickle windows advance only on clock edges where `tick`=1. With `tick` held low, the window keeps its current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 3 | Charge phase code from the sequencer |
| tm_a | input | 2 | First timer-mode selection, three-level code |
| tm_b | input | 2 | Second timer-mode selection, three-level code |
| ext_reg | input | 1 | 1 when an external regulator is used and sense is grounded |
| sense_lo | input | 1 | Sense voltage below the low threshold |
| sense_hi | input | 1 | Sense voltage above the high threshold |
| tick | input | 1 | Time-base tick, one-cycle pulse |
| gate_en | output | 1 | Charge switch enable |

## Verification
The bench sweeps every phase over all nine mode-code pairs and compares each cycle against window formulas worked out by arithmetic. This sweep would catch a top-off window that also opened when `tm_b` was float, or a trickle period that ignored the top-off selection and produced the wrong duty. It also targets the simultaneous assertion of both sense flags: if the low flag had priority, the switch would close against an over-current. It also requests an early re-enable just after a turn-off, to expose a missing or off-by-one minimum hold, which would let the enable chatter faster than allowed. Holding `tick` low inside the on-part of top-off checks that the window does not run on the clock instead of the time base.

// File: rtl/chg_gate_pkg.sv
package chg_gate_pkg;

    // phase codes from the charge sequencer
    localparam logic [2:0] PH_OFF    = 3'd0;
    localparam logic [2:0] PH_PEND   = 3'd1;
    localparam logic [2:0] PH_FAST   = 3'd2;
    localparam logic [2:0] PH_TOPOFF = 3'd3;
    localparam logic [2:0] PH_MAINT  = 3'd4;

    // three-level mode codes; any other code reads as float
    localparam logic [1:0] TM_LOW  = 2'b00;
    localparam logic [1:0] TM_HIGH = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FAST,
        S_TOP_ON,
        S_TOP_OFF,
        S_TRK_ON,
        S_TRK_WAIT
    } win_state_e;

endpackage

// File: rtl/chg_gate_mode.sv
module chg_gate_mode
    import chg_gate_pkg::*;
(
    input  logic [1:0] tm_a,
    input  logic [1:0] tm_b,
    output logic       top_en,
    output logic       trk_en,
    output logic       trk_long
);

    always_comb begin
        top_en   = (tm_b == TM_HIGH);
        trk_en   = !((tm_a == TM_LOW) && (tm_b == TM_LOW));
        // slower trickle when top-off also delivers charge
        trk_long = top_en;
    end

endmodule

// File: rtl/chg_gate_hyst.sv
module chg_gate_hyst #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_lo,
    input  logic sense_hi,
    output logic hys_on
);

    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hold_q;
    logic          on_q;
    logic          want;

    always_comb begin
        if (sense_hi)      want = 1'b0;
        else if (sense_lo) want = 1'b1;
        else               want = on_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            hold_q <= '0;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
        end else if (want != on_q) begin
            on_q   <= want;
            hold_q <= HW'(HOLD_CYC - 1);
        end
    end

    assign hys_on = on_q;

endmodule

// File: rtl/chg_gate_win.sv
module chg_gate_win
    import chg_gate_pkg::*;
#(
    parameter int PULSE_TICKS   = 2,
    parameter int TOP_ON_TICKS  = 4,
    parameter int TOP_OFF_TICKS = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] phase,
    input  logic       tick,
    input  logic       top_en,
    input  logic       trk_en,
    input  logic       trk_long,
    output logic       win_on
);

    localparam int TRK_LONG_PER  = 64 * PULSE_TICKS;
    localparam int TRK_SHORT_PER = 32 * PULSE_TICKS;
    localparam int MAX_A  = (TOP_ON_TICKS > TOP_OFF_TICKS) ? TOP_ON_TICKS : TOP_OFF_TICKS;
    localparam int MAXLEN = (MAX_A > TRK_LONG_PER) ? MAX_A : TRK_LONG_PER;
    localparam int CW     = $clog2(MAXLEN + 1);

    win_state_e    st_q, st_n, target;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] wait_last;
    logic          same_kind;

    always_comb begin
        unique case (phase)
            PH_FAST:           target = S_FAST;
            PH_TOPOFF:         target = top_en ? S_TOP_ON : S_IDLE;
            PH_PEND, PH_MAINT: target = trk_en ? S_TRK_ON : S_IDLE;
            default:           target = S_IDLE;
        endcase
        same_kind = (st_q == target)
                 || (target == S_TOP_ON && st_q == S_TOP_OFF)
                 || (target == S_TRK_ON && st_q == S_TRK_WAIT);
        wait_last = trk_long ? CW'(TRK_LONG_PER - PULSE_TICKS - 1)
                             : CW'(TRK_SHORT_PER - PULSE_TICKS - 1);
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (!same_kind) begin
            st_n  = target;
            cnt_n = '0;
        end else if (tick) begin
            unique case (st_q)
                S_TOP_ON: begin
                    if (cnt_q >= CW'(TOP_ON_TICKS - 1)) begin st_n = S_TOP_OFF; cnt_n = '0; end
                    else cnt_n = cnt_q + CW'(1);
                end
                S_TOP_OFF: begin
                    if (cnt_q >= CW'(TOP_OFF_TICKS - 1)) begin st_n = S_TOP_ON; cnt_n = '0; end
                    else cnt_n = cnt_q + CW'(1);
                end
                S_TRK_ON: begin
                    if (cnt_q >= CW'(PULSE_TICKS - 1)) begin st_n = S_TRK_WAIT; cnt_n = '0; end
                    else cnt_n = cnt_q + CW'(1);
                end
                S_TRK_WAIT: begin
                    if (cnt_q >= wait_last) begin st_n = S_TRK_ON; cnt_n = '0; end
                    else cnt_n = cnt_q + CW'(1);
                end
                default: begin
                    st_n  = st_q;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign win_on = (st_q == S_FAST) || (st_q == S_TOP_ON) || (st_q == S_TRK_ON);

endmodule

// File: rtl/chg_gate_mod.sv
module chg_gate_mod #(
    parameter int PULSE_TICKS   = 2,
    parameter int TOP_ON_TICKS  = 4,
    parameter int TOP_OFF_TICKS = 30,
    parameter int HOLD_CYC      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] phase,
    input  logic [1:0] tm_a,
    input  logic [1:0] tm_b,
    input  logic       ext_reg,
    input  logic       sense_lo,
    input  logic       sense_hi,
    input  logic       tick,
    output logic       gate_en
);

    logic top_en, trk_en, trk_long;
    logic win_on, hys_on;
    logic gate_q;

    chg_gate_mode mode_i (
        .tm_a    (tm_a),
        .tm_b    (tm_b),
        .top_en  (top_en),
        .trk_en  (trk_en),
        .trk_long(trk_long)
    );

    chg_gate_hyst #(.HOLD_CYC(HOLD_CYC)) hyst_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_lo(sense_lo),
        .sense_hi(sense_hi),
        .hys_on  (hys_on)
    );

    chg_gate_win #(
        .PULSE_TICKS  (PULSE_TICKS),
        .TOP_ON_TICKS (TOP_ON_TICKS),
        .TOP_OFF_TICKS(TOP_OFF_TICKS)
    ) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .tick    (tick),
        .top_en  (top_en),
        .trk_en  (trk_en),
        .trk_long(trk_long),
        .win_on  (win_on)
    );

    // output register: glitch-free drive of the switch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= win_on & (ext_reg | hys_on);
    end

    assign gate_en = gate_q;

endmodule

// File: rtl/chg_gate_mod_chk.sv
module chg_gate_mod_chk #(
    parameter int HOLD_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase,
    input logic [1:0] tm_a,
    input logic [1:0] tm_b,
    input logic       ext_reg,
    input logic       win_on,
    input logic       hys_on,
    input logic       gate_en
);

    localparam int GW = $clog2(HOLD_CYC + 1) + 1;

    logic          ph_off, ph_trk;
    logic          hys_prev, seen;
    logic [GW-1:0] gap;

    assign ph_off = (phase == 3'd0) || (phase > 3'd4);
    assign ph_trk = (phase == 3'd1) || (phase == 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hys_prev <= 1'b0;
            seen     <= 1'b0;
            gap      <= '0;
        end else begin
            hys_prev <= hys_on;
            if (hys_on != hys_prev) begin
                gap  <= GW'(1);
                seen <= 1'b1;
            end else if (gap < GW'(HOLD_CYC)) begin
                gap <= gap + GW'(1);
            end
        end
    end

    // R2
    off_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_off |=> ##1 !gate_en);

    // R4
    hold_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hys_on != hys_prev) && seen |-> gap >= GW'(HOLD_CYC));

    // R5
    ext_follows_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_reg && win_on |=> gate_en);

    // R3
    hys_off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_reg && !hys_on |=> !gate_en);

    // R6
    gate_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> $past(win_on));

    // R7
    top_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) && (tm_b != 2'b10) |=> !win_on);

    // R9
    trk_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_trk && (tm_a == 2'b00) && (tm_b == 2'b00) |=> !win_on);

endmodule

bind chg_gate_mod chg_gate_mod_chk #(.HOLD_CYC(HOLD_CYC)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .tm_a   (tm_a),
    .tm_b   (tm_b),
    .ext_reg(ext_reg),
    .win_on (win_on),
    .hys_on (hys_on),
    .gate_en(gate_en)
);

// File: tb/chg_gate_mod_tb_top.sv
module chg_gate_mod_tb_top;

    localparam int P   = 2;
    localparam int ON  = 4;
    localparam int OFF = 30;
    localparam int H   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] phase = 3'd0;
    logic [1:0] tm_a = 2'b00;
    logic [1:0] tm_b = 2'b00;
    logic       ext_reg = 1'b0;
    logic       sense_lo = 1'b0;
    logic       sense_hi = 1'b0;
    logic       tick = 1'b0;
    logic       gate_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    chg_gate_mod #(
        .PULSE_TICKS(P), .TOP_ON_TICKS(ON), .TOP_OFF_TICKS(OFF), .HOLD_CYC(H)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .phase(phase), .tm_a(tm_a), .tm_b(tm_b),
        .ext_reg(ext_reg), .sense_lo(sense_lo), .sense_hi(sense_hi),
        .tick(tick), .gate_en(gate_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: gate_en=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic nstep(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [1:0] code(input int i);
        return (i == 0) ? 2'b00 : (i == 1) ? 2'b01 : 2'b10;
    endfunction

    function automatic int exp_win(input logic [2:0] ph, input logic [1:0] a,
                                   input logic [1:0] b, input int k);
        bit top = (b == 2'b10);
        bit trk = !(a == 2'b00 && b == 2'b00);
        int per = top ? 64 * P : 32 * P;
        if (ph == 3'd2) return 1;
        if (ph == 3'd3) return top ? int'(((k - 1) % (ON + OFF)) < ON) : 0;
        if (ph == 3'd1 || ph == 3'd4) return trk ? int'(((k - 1) % per) < P) : 0;
        return 0;
    endfunction

    // enter a phase from off and compare cycle by cycle
    task automatic run_win(input string req, input logic [2:0] ph,
                           input logic [1:0] a, input logic [1:0] b, input int n,
                           input bit force_off);
        phase = 3'd0;
        nstep(3);
        chk(req, gate_en, 0);
        phase = ph; tm_a = a; tm_b = b;
        nstep(1);
        for (int k = 1; k <= n; k++) begin
            nstep(1);
            chk(req, gate_en, force_off ? 0 : exp_win(ph, a, b, k));
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: gate_en=%0d expected 0 (timeout)", gate_en);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        nstep(3);
        chk("R1", gate_en, 0);
        rst_n = 1'b1;
        nstep(1);
        chk("R1", gate_en, 0);

        // R3 / R6 hysteresis in fast charge
        phase = 3'd2; sense_lo = 1'b1;
        nstep(1);
        chk("R6", gate_en, 0);
        nstep(1);
        chk("R3", gate_en, 1);
        nstep(10);
        sense_lo = 1'b0;
        for (int i = 0; i < 10; i++) begin nstep(1); chk("R3", gate_en, 1); end
        sense_hi = 1'b1;
        nstep(1);
        chk("R3", gate_en, 1);
        nstep(1);
        chk("R3", gate_en, 0);
        nstep(10);
        sense_lo = 1'b1;
        for (int i = 0; i < 10; i++) begin nstep(1); chk("R3", gate_en, 0); end
        sense_hi = 1'b0;
        nstep(2);
        chk("R3", gate_en, 1);
        nstep(10);

        // R4 early re-enable after a turn-off
        sense_lo = 1'b0; sense_hi = 1'b1;
        nstep(1);
        sense_hi = 1'b0; sense_lo = 1'b1;
        for (int k = 1; k <= H + 3; k++) begin
            nstep(1);
            chk("R4", gate_en, (k <= H) ? 0 : 1);
        end

        // R5 sense ignored with an external regulator
        nstep(10);
        ext_reg = 1'b1; sense_lo = 1'b0; sense_hi = 1'b1;
        for (int i = 0; i < 20; i++) begin nstep(1); chk("R5", gate_en, 1); end

        // R2 off codes force low even with ext_reg
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            phase = 3'd2;
            nstep(3);
            phase = 3'(c);
            nstep(2);
            for (int i = 0; i < 5; i++) begin nstep(1); chk("R2", gate_en, 0); end
        end

        // R7 / R8 / R9 sweep of windows over all mode pairs, tick every cycle
        tick = 1'b1;
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                run_win("R7", 3'd3, code(a), code(b), 2 * (ON + OFF) + 2, 1'b0);
                run_win((a == 0 && b == 0) ? "R9" : "R8", 3'd1, code(a), code(b),
                        (b == 2) ? 64 * P + 6 : 2 * 32 * P + 4, 1'b0);
                run_win((a == 0 && b == 0) ? "R9" : "R8", 3'd4, code(a), code(b),
                        (b == 2) ? 64 * P + 6 : 2 * 32 * P + 4, 1'b0);
            end
        end

        // R6 window with internal regulation: on state passes, off state blocks
        ext_reg = 1'b0; sense_hi = 1'b0; sense_lo = 1'b1;
        nstep(10);
        run_win("R6", 3'd3, 2'b01, 2'b10, ON + OFF + 4, 1'b0);
        sense_lo = 1'b0; sense_hi = 1'b1;
        nstep(10);
        run_win("R3", 3'd3, 2'b01, 2'b10, ON + OFF + 4, 1'b1);

        // R10 window holds without ticks
        ext_reg = 1'b1; sense_hi = 1'b0;
        phase = 3'd0;
        nstep(3);
        tick = 1'b0; tm_b = 2'b10; phase = 3'd3;
        nstep(2);
        for (int i = 0; i < 60; i++) begin nstep(1); chk("R10", gate_en, 1); end
        tick = 1'b1;
        for (int j = 1; j <= 6; j++) begin
            nstep(1);
            chk("R10", gate_en, (j <= ON) ? 1 : 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule